// File: doc/BRIEF.md
# NAND Page Read Command Sequencer

This block performs the command and address part of a raw NAND flash page read over an 8-bit bus. A host gives it a block number, a page within that block, a byte column and a command byte, and then pulses `start_i`. The sequencer first waits until the flash is idle. Then it latches the command byte with the command strobe and the address bytes with the address strobe. For large-page parts it adds a confirm command. It then drops both strobes, waits for the flash a second time, and pulses `done_o`. Data transfer after the address phase is left to other logic.

Two parameters set the device format. `LARGE_PAGE` chooses between a small-page device (one column byte, no confirm) and a large-page device (two column bytes and a 0x30 confirm). `EXTRA_ROW` adds one more row byte for bigger devices. On a large-page device, a spare-area read request (command 0x50) is sent as an ordinary read (0x00), with the page size added to the column. The wait before and after the bus phase follows the synchronised ready/busy input when `USE_RDY` is 1. When `USE_RDY` is 0, the wait is a fixed count of `WAIT_CYCLES` instead.

The controller has eight states:
- `S_IDLE` moves to `S_PRE_WAIT` on `start_i` and latches the operands.
- `S_PRE_WAIT` moves to `S_CMD` when the wait gate opens.
- `S_CMD` moves to `S_ADDR` after one byte strobe.
- `S_ADDR` runs one strobe per address byte. After the last byte it moves to `S_CONFIRM` on a large-page device, or to `S_RELEASE` otherwise.
- `S_CONFIRM` moves to `S_RELEASE` after its strobe.
- `S_RELEASE` moves to `S_POST_WAIT` unconditionally.
- `S_POST_WAIT` moves to `S_DONE` when the gate opens.
- `S_DONE` returns to `S_IDLE`.

Each byte strobe has three phases: setup, write-enable low, and hold.

Top module: `nand_rd_seq`

## Requirements
- R1: Out of reset, and while idle, `busy_o`=0, `done_o`=0, `cle_o`=0, `ale_o`=0, `we_n_o`=1 and `ce_n_o`=1.
- R2: The row is `pg_i + blk_i*PAGES_PER_BLK`. The first row byte carries row bits [7:0] and the second carries row bits [15:8]. Both are latched with `ale_o`=1.
- R3: Small-page order: the command byte with `cle_o`=1, then column bits [7:0], then the two row bytes. That is 3 address bytes, or 4 with `EXTRA_ROW`. A command is passed through unchanged.
- R4: Large-page order: the command, then column low byte, then column high byte (column bits [11:8], zero-extended), then the two row bytes. With `EXTRA_ROW`, a fifth address byte `{4'h0,row[19:16]}` follows.
- R5: On a large-page device, command 0x50 is sent as 0x00, and the column sent is `col_i + PAGE_BYTES`. Any other command keeps its value and column.
- R6: On a large-page device, the address bytes are followed by the byte 0x30 latched with `cle_o`=1.
- R7: Each byte is latched by `we_n_o` going low for exactly one cycle. `io_o`, `cle_o` and `ale_o` stay stable from the cycle before the low cycle through the cycle after it. `cle_o` and `ale_o` are never both high.
- R8: No strobe occurs before the flash is ready. With `USE_RDY`=1, the first byte is latched 5 cycles after `rdy_i` rises: 2 of those cycles are synchronisation. With `USE_RDY`=0, the wait lasts `WAIT_CYCLES`+1 cycles.
- R9: After the strobes are released, `done_o` waits again. With `USE_RDY`=1, `done_o` appears 3 cycles after `rdy_i` rises. With `USE_RDY`=0, a read lasts `2*WAIT_CYCLES+3+3*bytes` cycles from the accepting edge to `done_o`.
- R10: `done_o` is high for exactly one cycle. `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. `ce_n_o` is low exactly while busy.
- R11: A `start_i` pulse while busy is ignored. The running read keeps its latched operands and its timing.
- R12: Outside the byte-latch states, `cle_o` and `ale_o` are low and `we_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| blk_i | input | BLK_W | Block number |
| pg_i | input | PG_W | Page within block |
| col_i | input | COL_W | Column byte offset |
| cmd_i | input | 8 | Read command byte |
| rdy_i | input | 1 | Flash ready/busy, 1 = ready |
| busy_o | output | 1 | Sequencer active |
| done_o | output | 1 | One-cycle completion pulse |
| io_o | output | 8 | Bus byte to the flash |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Write enable, active low |
| ce_n_o | output | 1 | Chip enable, active low |

## Verification
The bench drives two instances from the same stimulus. The first is a large-page device with the extra row byte and a fixed 4-cycle wait, which exercises the spare-area conversion, the confirm command, the fifth address byte and exact read lengths. The second is a small-page device without the extra byte that waits on the ready input with 32 pages per block, which exercises the ready gating before and after the bus phase and a different row multiplier. Random block, page and column values are mixed with corner cases at row zero, the maximum row, and a column near the top of the page.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int ADDR_SLOTS = 5;
    localparam int IDX_W      = $clog2(ADDR_SLOTS + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE_WAIT,
        S_CMD,
        S_ADDR,
        S_CONFIRM,
        S_RELEASE,
        S_POST_WAIT,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_SETUP,
        PH_LOW,
        PH_HOLD
    } strobe_ph_t;

    function automatic strobe_ph_t ph_next(strobe_ph_t p);
        unique case (p)
            PH_SETUP: return PH_LOW;
            PH_LOW:   return PH_HOLD;
            default:  return PH_SETUP;
        endcase
    endfunction

endpackage

// File: rtl/nand_row_calc.sv
module nand_row_calc #(
    parameter int BLK_W         = 14,
    parameter int PG_W          = 6,
    parameter int PAGES_PER_BLK = 64,
    parameter int ROW_W         = 20
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [PG_W-1:0]  pg,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] PPB = ROW_W'(PAGES_PER_BLK);

    always_comb begin
        row = ROW_W'(pg) + ROW_W'(blk) * PPB;
    end
endmodule

// File: rtl/nand_addr_plan.sv
module nand_addr_plan
    import nand_seq_pkg::*;
#(
    parameter bit         LARGE_PAGE = 1'b1,
    parameter bit         EXTRA_ROW  = 1'b1,
    parameter int         COL_W      = 12,
    parameter int         ROW_W      = 20,
    parameter int         PAGE_BYTES = 2048,
    parameter logic [7:0] CMD_SPARE  = 8'h50,
    parameter logic [7:0] CMD_READ   = 8'h00
) (
    input  logic [7:0]                  cmd,
    input  logic [COL_W-1:0]            col,
    input  logic [ROW_W-1:0]            row,
    output logic [7:0]                  cmd_eff,
    output logic [ADDR_SLOTS-1:0][7:0]  abytes,
    output logic [IDX_W-1:0]            n_addr
);
    localparam logic [COL_W-1:0] PB = COL_W'(PAGE_BYTES);

    generate
        if (LARGE_PAGE) begin : g_large
            logic [COL_W-1:0] col_eff;
            always_comb begin
                if (cmd == CMD_SPARE) begin
                    cmd_eff = CMD_READ;
                    col_eff = col + PB;
                end else begin
                    cmd_eff = cmd;
                    col_eff = col;
                end
                abytes[0] = col_eff[7:0];
                abytes[1] = 8'(col_eff >> 8);
                abytes[2] = row[7:0];
                abytes[3] = row[15:8];
                abytes[4] = {4'h0, row[19:16]};
                n_addr    = EXTRA_ROW ? IDX_W'(5) : IDX_W'(4);
            end
        end else begin : g_small
            always_comb begin
                cmd_eff   = cmd;
                abytes[0] = col[7:0];
                abytes[1] = row[7:0];
                abytes[2] = row[15:8];
                abytes[3] = {4'h0, row[19:16]};
                abytes[4] = 8'h00;
                n_addr    = EXTRA_ROW ? IDX_W'(4) : IDX_W'(3);
            end
        end
    endgenerate
endmodule

// File: rtl/nand_wait_gate.sv
module nand_wait_gate #(
    parameter bit USE_RDY     = 1'b1,
    parameter int WAIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic rdy,
    output logic open_o
);
    generate
        if (USE_RDY) begin : g_rdy
            logic s1, s2;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                end else begin
                    s1 <= rdy;
                    s2 <= s1;
                end
            end
            assign open_o = arm && s2;
        end else begin : g_delay
            localparam int CNT_W = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);
            localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT_CYCLES);
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= LOAD;
                end else if (!arm) begin
                    cnt <= LOAD;
                end else if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end
            end
            assign open_o = arm && (cnt == '0);
        end
    endgenerate
endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
    import nand_seq_pkg::*;
#(
    parameter bit         LARGE_PAGE    = 1'b1,
    parameter bit         EXTRA_ROW     = 1'b1,
    parameter bit         USE_RDY       = 1'b1,
    parameter int         WAIT_CYCLES   = 16,
    parameter int         BLK_W         = 14,
    parameter int         PG_W          = 6,
    parameter int         COL_W         = 12,
    parameter int         ROW_W         = 20,
    parameter int         PAGES_PER_BLK = 64,
    parameter int         PAGE_BYTES    = 2048,
    parameter logic [7:0] CMD_SPARE     = 8'h50,
    parameter logic [7:0] CMD_READ      = 8'h00,
    parameter logic [7:0] CMD_CONFIRM   = 8'h30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] blk_i,
    input  logic [PG_W-1:0]  pg_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [7:0]       cmd_i,
    input  logic             rdy_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [7:0]       io_o,
    output logic             cle_o,
    output logic             ale_o,
    output logic             we_n_o,
    output logic             ce_n_o
);
    seq_state_t state_q, state_d;
    strobe_ph_t ph_q, ph_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    logic [BLK_W-1:0] blk_q;
    logic [PG_W-1:0]  pg_q;
    logic [COL_W-1:0] col_q;
    logic [7:0]       cmd_q;

    logic [ROW_W-1:0]                row;
    logic [7:0]                      cmd_eff;
    logic [ADDR_SLOTS-1:0][7:0]      abytes;
    logic [IDX_W-1:0]                n_addr;
    logic                            gate_arm, gate_open;
    logic                            strobe_end;

    nand_row_calc #(
        .BLK_W(BLK_W), .PG_W(PG_W),
        .PAGES_PER_BLK(PAGES_PER_BLK), .ROW_W(ROW_W)
    ) u_row (
        .blk(blk_q), .pg(pg_q), .row(row)
    );

    nand_addr_plan #(
        .LARGE_PAGE(LARGE_PAGE), .EXTRA_ROW(EXTRA_ROW),
        .COL_W(COL_W), .ROW_W(ROW_W), .PAGE_BYTES(PAGE_BYTES),
        .CMD_SPARE(CMD_SPARE), .CMD_READ(CMD_READ)
    ) u_plan (
        .cmd(cmd_q), .col(col_q), .row(row),
        .cmd_eff(cmd_eff), .abytes(abytes), .n_addr(n_addr)
    );

    nand_wait_gate #(
        .USE_RDY(USE_RDY), .WAIT_CYCLES(WAIT_CYCLES)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .arm(gate_arm),
        .rdy(rdy_i), .open_o(gate_open)
    );

    assign gate_arm   = (state_q == S_PRE_WAIT) || (state_q == S_POST_WAIT);
    assign strobe_end = (ph_q == PH_HOLD);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_d = S_PRE_WAIT;
            end
            S_PRE_WAIT: begin
                if (gate_open) begin
                    state_d = S_CMD;
                    ph_d    = PH_SETUP;
                end
            end
            S_CMD: begin
                ph_d = ph_next(ph_q);
                if (strobe_end) begin
                    state_d = S_ADDR;
                    idx_d   = '0;
                end
            end
            S_ADDR: begin
                ph_d = ph_next(ph_q);
                if (strobe_end) begin
                    if (idx_q == n_addr - 1'b1) begin
                        state_d = LARGE_PAGE ? S_CONFIRM : S_RELEASE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            S_CONFIRM: begin
                ph_d = ph_next(ph_q);
                if (strobe_end) state_d = S_RELEASE;
            end
            S_RELEASE: begin
                state_d = S_POST_WAIT;
            end
            S_POST_WAIT: begin
                if (gate_open) state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ph_q    <= PH_SETUP;
            idx_q   <= '0;
            blk_q   <= '0;
            pg_q    <= '0;
            col_q   <= '0;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            idx_q   <= idx_d;
            if (state_q == S_IDLE && start_i) begin
                blk_q <= blk_i;
                pg_q  <= pg_i;
                col_q <= col_i;
                cmd_q <= cmd_i;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o = (state_q != S_IDLE);
        done_o = (state_q == S_DONE);
        ce_n_o = (state_q == S_IDLE);
        cle_o  = 1'b0;
        ale_o  = 1'b0;
        we_n_o = 1'b1;
        io_o   = 8'h00;
        unique case (state_q)
            S_CMD: begin
                cle_o  = 1'b1;
                io_o   = cmd_eff;
                we_n_o = (ph_q != PH_LOW);
            end
            S_ADDR: begin
                ale_o  = 1'b1;
                io_o   = abytes[idx_q];
                we_n_o = (ph_q != PH_LOW);
            end
            S_CONFIRM: begin
                cle_o  = 1'b1;
                io_o   = CMD_CONFIRM;
                we_n_o = (ph_q != PH_LOW);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nand_rd_seq_chk.sv
module nand_rd_seq_chk #(
    parameter bit USE_RDY = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       rdy,
    input logic       busy,
    input logic       done,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic [7:0] io
);
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    a_r7_low_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> we_n);

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> ($stable(io) && $stable(cle) && $stable(ale)));

    a_r7_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> ($stable(io) && $stable(cle) && $stable(ale)));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cle && !ale && we_n));

    // R9: two synchroniser stages plus the exit edge give a 3-cycle lag
    a_r9_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (USE_RDY && done) |-> $past(rdy, 3));
endmodule

bind nand_rd_seq nand_rd_seq_chk #(.USE_RDY(USE_RDY)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start_i), .rdy(rdy_i),
    .busy(busy_o), .done(done_o), .cle(cle_o), .ale(ale_o),
    .we_n(we_n_o), .io(io_o)
);

// File: tb/tb_nand_rd_seq.sv
`timescale 1ns/1ps
module tb_nand_rd_seq;
    localparam int PPB_L = 64;
    localparam int PPB_S = 32;
    localparam int NW    = 4;
    localparam int DUR_L = 2*NW + 3 + 3*7;
    localparam int DUR_S = 3 + 3*4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [13:0] blk = '0;
    logic [5:0]  pg = '0;
    logic [11:0] col = '0;
    logic [7:0]  cmd = '0;
    logic        rdy = 1'b1;

    logic busy_l, done_l, cle_l, ale_l, we_l, ce_l;
    logic busy_s, done_s, cle_s, ale_s, we_s, ce_s;
    logic [7:0] io_l, io_s;

    nand_rd_seq #(.LARGE_PAGE(1'b1), .EXTRA_ROW(1'b1), .USE_RDY(1'b0),
        .WAIT_CYCLES(NW), .PAGES_PER_BLK(PPB_L), .PAGE_BYTES(2048)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .blk_i(blk), .pg_i(pg),
        .col_i(col), .cmd_i(cmd), .rdy_i(rdy), .busy_o(busy_l), .done_o(done_l),
        .io_o(io_l), .cle_o(cle_l), .ale_o(ale_l), .we_n_o(we_l), .ce_n_o(ce_l));

    nand_rd_seq #(.LARGE_PAGE(1'b0), .EXTRA_ROW(1'b0), .USE_RDY(1'b1),
        .PAGES_PER_BLK(PPB_S), .PAGE_BYTES(512)) dut_sp (
        .clk(clk), .rst_n(rst_n), .start_i(start), .blk_i(blk), .pg_i(pg),
        .col_i(col), .cmd_i(cmd), .rdy_i(rdy), .busy_o(busy_s), .done_o(done_s),
        .io_o(io_s), .cle_o(cle_s), .ale_o(ale_s), .we_n_o(we_s), .ce_n_o(ce_s));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0;
    bit finished = 1'b0;

    // capture monitors: {cle, ale, io}
    logic [9:0] capL [0:15];
    logic [9:0] capS [0:15];
    int ncapL = 0, ncapS = 0;
    int firstL = -1, firstS = -1;
    int doneL = -1, doneS = -1;
    int dhL = 0, dhS = 0;
    bit badL = 0, badS = 0;
    logic pwL = 1'b1, pwS = 1'b1;
    logic [9:0] lowL, lowS;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cle_l && ale_l) badL = 1;
            if (!we_l) lowL = {cle_l, ale_l, io_l};
            if (!pwL && we_l) begin
                if (lowL != {cle_l, ale_l, io_l}) badL = 1;
                if (ncapL == 0) firstL = cyc;
                if (ncapL < 16) capL[ncapL] = {cle_l, ale_l, io_l};
                ncapL++;
            end
            pwL = we_l;
            if (done_l) begin
                if (doneL < 0) doneL = cyc;
                dhL++;
                if (dhL > 1) badL = 1;
            end else dhL = 0;

            if (cle_s && ale_s) badS = 1;
            if (!we_s) lowS = {cle_s, ale_s, io_s};
            if (!pwS && we_s) begin
                if (lowS != {cle_s, ale_s, io_s}) badS = 1;
                if (ncapS == 0) firstS = cyc;
                if (ncapS < 16) capS[ncapS] = {cle_s, ale_s, io_s};
                ncapS++;
            end
            pwS = we_s;
            if (done_s) begin
                if (doneS < 0) doneS = cyc;
                dhS++;
                if (dhS > 1) badS = 1;
            end else dhS = 0;
        end
    end

    logic [9:0] expL [0:7];
    logic [9:0] expS [0:7];
    int start_cyc;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic build_exp(input int b, input int p, input int c, input int k);
        int rl, rs, ce;
        logic [7:0] ck;
        rl = p + b * PPB_L;
        rs = p + b * PPB_S;
        ck = (k == 8'h50) ? 8'h00 : 8'(k);
        ce = (k == 8'h50) ? c + 2048 : c;
        expL[0] = {2'b10, ck};
        expL[1] = {2'b01, 8'(ce & 8'hFF)};
        expL[2] = {2'b01, 8'((ce >> 8) & 8'h0F)};
        expL[3] = {2'b01, 8'(rl & 8'hFF)};
        expL[4] = {2'b01, 8'((rl >> 8) & 8'hFF)};
        expL[5] = {2'b01, 8'((rl >> 16) & 8'h0F)};
        expL[6] = {2'b10, 8'h30};
        expS[0] = {2'b10, 8'(k)};
        expS[1] = {2'b01, 8'(c & 8'hFF)};
        expS[2] = {2'b01, 8'(rs & 8'hFF)};
        expS[3] = {2'b01, 8'((rs >> 8) & 8'hFF)};
    endtask

    task automatic clear_mon();
        ncapL = 0; ncapS = 0; firstL = -1; firstS = -1;
        doneL = -1; doneS = -1; badL = 0; badS = 0;
    endtask

    task automatic launch(input int b, input int p, input int c, input int k);
        @(negedge clk);
        blk = 14'(b); pg = 6'(p); col = 12'(c); cmd = 8'(k);
        build_exp(b, p, c, k);
        clear_mon();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        start_cyc = cyc;
    endtask

    task automatic wait_both();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); #1;
            if (doneL >= 0 && doneS >= 0) break;
        end
        chk(doneL >= 0 && doneS >= 0, "R10", "both reads completed", doneL, doneS);
    endtask

    task automatic check_bytes(input bit ign, input bit sdur);
        string tl [0:6];
        string ts [0:3];
        tl = '{"R5", "R4", "R4", "R2", "R2", "R4", "R6"};
        ts = '{"R3", "R3", "R2", "R2"};
        chk(ncapL == 7, "R4", "large byte count", ncapL, 7);
        chk(ncapS == 4, "R3", "small byte count", ncapS, 4);
        for (int i = 0; i < 7; i++)
            chk(capL[i] == expL[i], ign ? "R11" : tl[i], $sformatf("large byte %0d", i),
                int'(capL[i]), int'(expL[i]));
        for (int i = 0; i < 4; i++)
            chk(capS[i] == expS[i], ign ? "R11" : ts[i], $sformatf("small byte %0d", i),
                int'(capS[i]), int'(expS[i]));
        chk(!badL && !badS, "R7", "strobe shape", int'({badL, badS}), 0);
        chk(doneL - start_cyc == DUR_L, ign ? "R11" : "R9", "large duration",
            doneL - start_cyc, DUR_L);
        chk(firstL - start_cyc == NW + 3, "R8", "large first latch",
            firstL - start_cyc, NW + 3);
        if (sdur) begin
            chk(doneS - start_cyc == DUR_S, "R8", "small duration", doneS - start_cyc, DUR_S);
            chk(firstS - start_cyc == 3, "R8", "small first latch", firstS - start_cyc, 3);
        end
        repeat (3) @(negedge clk);
        chk(!busy_l && !busy_s && ce_l && ce_s, "R10", "idle after done",
            int'({busy_l, busy_s, ce_l, ce_s}), 3);
    endtask

    task automatic one_read(input int b, input int p, input int c, input int k);
        launch(b, p, c, k);
        chk(busy_l && busy_s && !ce_l && !ce_s, "R10", "busy after start",
            int'({busy_l, busy_s, ce_l, ce_s}), 12);
        wait_both();
        check_bytes(1'b0, 1'b1);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int rc, b, p, c, k;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy_l && !done_l && !cle_l && !ale_l && we_l && ce_l, "R1", "large reset",
            int'({busy_l, done_l, cle_l, ale_l, we_l, ce_l}), 3);
        chk(!busy_s && !done_s && !cle_s && !ale_s && we_s && ce_s, "R1", "small reset",
            int'({busy_s, done_s, cle_s, ale_s, we_s, ce_s}), 3);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_l && !busy_s && we_l && we_s, "R1", "idle after reset",
            int'({busy_l, busy_s, we_l, we_s}), 3);

        // directed corners: row zero, maximum row, column near page top
        one_read(0, 0, 0, 8'h00);
        one_read(16383, 63, 2047, 8'h50);
        one_read(16383, 63, 2047, 8'h00);
        one_read(1, 0, 255, 8'h50);

        // random reads
        for (int n = 0; n < 24; n++) begin
            b = int'($urandom_range(0, 16383));
            p = int'($urandom_range(0, 63));
            c = int'($urandom_range(0, 2047));
            k = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'h50;
            one_read(b, p, c, k);
        end

        // R11: start while busy with different operands
        launch(77, 5, 300, 8'h50);
        repeat (3) @(negedge clk);
        blk = 14'd9000; pg = 6'd33; col = 12'd1; cmd = 8'h00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_both();
        check_bytes(1'b1, 1'b1);

        // R8 / R9: small device gated by ready
        rdy = 1'b0;
        repeat (4) @(negedge clk);
        launch(300, 7, 18, 8'h00);
        repeat (8) @(negedge clk);
        #1;
        chk(ncapS == 0 && busy_s, "R8", "no latch while not ready", ncapS, 0);
        @(negedge clk);
        rdy = 1'b1;
        rc = cyc;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); #1;
            if (ncapS >= 4) break;
        end
        rdy = 1'b0;
        chk(firstS == rc + 5, "R8", "first latch after ready", firstS - rc, 5);
        repeat (8) @(negedge clk);
        #1;
        chk(doneS < 0 && busy_s, "R9", "done held while not ready", doneS, -1);
        @(negedge clk);
        rdy = 1'b1;
        rc = cyc;
        wait_both();
        chk(doneS == rc + 3, "R9", "done after ready", doneS - rc, 3);
        check_bytes(1'b0, 1'b0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule